// File: doc/BRIEF.md
# Half-Bridge Dead-Time Interlock

This block sits between a pulse-width modulator and the two gate drivers of a half-bridge. It takes two request inputs, one for each switch of the pair, and produces two switch-enable outputs. A request that falls turns its output off with no added delay. An output may only turn on once the opposite output has been off for a programmed number of clock cycles. If the requests themselves already leave a wider gap, that gap counts toward the blanking interval and nothing is added to it. When both requests are high together, both outputs are driven off. A hold-off input forces both outputs off and restarts every blanking interval.

The blanking interval is `SCALE * min(dt_code, CODE_MAX) + OFFSET` cycles. `dt_code` is a runtime input and the other three terms are parameters. The requests and the hold-off input pass through a two-stage synchronizer, and each output comes straight from a state register. Each channel is driven by its own four-state machine:

- `CH_LOCK`: blocked, with the counter cleared.
- `CH_COUNT`: blanking in progress.
- `CH_READY`: blanking satisfied, output off.
- `CH_DRIVE`: output on.

A channel is blocked when the opposite synchronized request or the synchronized hold-off is high. Its transitions are:

- Any state goes to `CH_LOCK` while the channel is blocked.
- `CH_LOCK` goes to `CH_COUNT` when the block ends.
- `CH_COUNT` goes to `CH_DRIVE` (request high) or to `CH_READY` (request low) once the counter reaches the interval.
- `CH_READY` goes back to `CH_COUNT` if the interval grows above the counter, and goes to `CH_DRIVE` on a request.
- `CH_DRIVE` goes to `CH_READY` when its request falls.

Top module: `dti_interlock`

## Requirements
- R1: While `rst_n` is low both outputs are 0. After release, a request held high from reset first shows on its output at the (D+1)-th falling clock edge after release, where D is the interval below.
- R2: When a transition is permitted, an output follows its request three clock edges after the request is sampled. The latency is the same on both channels.
- R3: A request going low drives its output low three edges later, whatever the timer state.
- R4: D = SCALE*min(dt_code,CODE_MAX)+OFFSET (defaults 2, 3, 12). After one request falls and the opposite request rises in the same cycle, the opposite output rises D cycles after the first output fell. There are never fewer than D cycles with the opposite output low before any rise.
- R5: If the opposite request has already been low for at least D cycles, a rising request reaches its output with only the three-edge latency.
- R6: A request that rises while its interval is still running reaches the output exactly when the interval expires.
- R7: Whenever both synchronized requests are high, both outputs go low three edges after the overlap is sampled.
- R8: After an overlap, the interval for the request still high starts when the other request returns low.
- R9: A request that falls before its interval expires is cancelled, and its output never goes high.
- R10: While `hold_off` is high both outputs go low with the three-edge latency. After release, a high request waits a full interval D.
- R11: `out_a` and `out_b` are never high in the same cycle.
- R12: `dt_code` values above CODE_MAX give the same interval as CODE_MAX (27 cycles with the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_off | input | 1 | Forces both outputs off and restarts blanking |
| dt_code | input | CODE_W | Blanking interval code |
| in_a | input | 1 | Request for switch A |
| in_b | input | 1 | Request for switch B |
| out_a | output | 1 | Enable for switch A |
| out_b | output | 1 | Enable for switch B |

## Verification
The hardest case to reach from the ports is a channel sitting in `CH_COUNT` when its own request falls, or when the opposite request returns during the count. Random toggling almost never holds a request for fewer cycles than the interval at exactly the right moment. Directed sequences therefore bring one output on, swap the requests, and withdraw the new request a few cycles into the interval. They also stretch an overlap and release it, and release hold-off with a request already high. A seeded random phase then runs for each of several codes against a cycle-level model of the requirements, with a check of the low gap before every rising output.

// File: rtl/dti_pkg.sv
package dti_pkg;
    typedef enum logic [1:0] {
        CH_LOCK,
        CH_COUNT,
        CH_READY,
        CH_DRIVE
    } ch_state_t;
endpackage

// File: rtl/dti_sync.sv
module dti_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dti_delay.sv
module dti_delay #(
    parameter int CODE_W   = 4,
    parameter int SCALE    = 2,
    parameter int OFFSET   = 3,
    parameter int CODE_MAX = 12,
    parameter int DW       = 5
) (
    input  logic [CODE_W-1:0] code,
    output logic [DW-1:0]     delay
);
    localparam logic [CODE_W-1:0] CMAX_C  = CODE_W'(CODE_MAX);
    localparam logic [DW-1:0]     SCALE_C = DW'(SCALE);
    localparam logic [DW-1:0]     OFF_C   = DW'(OFFSET);

    logic [CODE_W-1:0] clamped;

    always_comb begin
        clamped = (code > CMAX_C) ? CMAX_C : code;
        delay   = SCALE_C * DW'(clamped) + OFF_C;
    end
endmodule

// File: rtl/dti_channel.sv
module dti_channel
    import dti_pkg::*;
#(
    parameter int DW   = 5,
    parameter int DMAX = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          block,
    input  logic [DW-1:0] delay,
    output logic          drive
);
    localparam logic [DW-1:0] DMAX_C = DW'(DMAX);

    ch_state_t     state, state_nx;
    logic [DW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_LOCK;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (block) begin
            cnt_nx = '0;
        end else if (cnt == DMAX_C) begin
            cnt_nx = cnt;
        end else begin
            cnt_nx = cnt + 1'b1;
        end
        unique case (state)
            CH_LOCK: begin
                if (!block) state_nx = CH_COUNT;
            end
            CH_COUNT: begin
                if (block)             state_nx = CH_LOCK;
                else if (cnt >= delay) state_nx = req ? CH_DRIVE : CH_READY;
            end
            CH_READY: begin
                if (block)            state_nx = CH_LOCK;
                else if (cnt < delay) state_nx = CH_COUNT;
                else if (req)         state_nx = CH_DRIVE;
            end
            CH_DRIVE: begin
                if (block)     state_nx = CH_LOCK;
                else if (!req) state_nx = CH_READY;
            end
            default: state_nx = CH_LOCK;
        endcase
    end

    always_comb begin
        drive = (state == CH_DRIVE);
    end

    assert_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !drive);
    assert_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> !drive);
    assert_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> $past(cnt >= delay));
endmodule

// File: rtl/dti_interlock.sv
module dti_interlock #(
    parameter int CODE_W   = 4,
    parameter int SCALE    = 2,
    parameter int OFFSET   = 3,
    parameter int CODE_MAX = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_off,
    input  logic [CODE_W-1:0] dt_code,
    input  logic              in_a,
    input  logic              in_b,
    output logic              out_a,
    output logic              out_b
);
    localparam int DMAX = SCALE * CODE_MAX + OFFSET;
    localparam int DW   = $clog2(DMAX + 1);
    localparam logic [DW-1:0] DMAX_C = DW'(DMAX);

    logic [2:0]    sync_q;
    logic [1:0]    req;
    logic [1:0]    drive;
    logic          dis_s;
    logic [DW-1:0] delay;

    dti_sync #(.WIDTH(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({hold_off, in_b, in_a}),
        .q    (sync_q)
    );

    assign req   = sync_q[1:0];
    assign dis_s = sync_q[2];

    dti_delay #(
        .CODE_W  (CODE_W),
        .SCALE   (SCALE),
        .OFFSET  (OFFSET),
        .CODE_MAX(CODE_MAX),
        .DW      (DW)
    ) u_delay (
        .code (dt_code),
        .delay(delay)
    );

    for (genvar i = 0; i < 2; i++) begin : g_ch
        logic          blk;
        logic [DW-1:0] quiet;

        assign blk = req[1-i] | dis_s;

        dti_channel #(.DW(DW), .DMAX(DMAX)) u_ch (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (req[i]),
            .block(blk),
            .delay(delay),
            .drive(drive[i])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                quiet <= '0;
            else if (drive[1-i])       quiet <= '0;
            else if (quiet != DMAX_C)  quiet <= quiet + 1'b1;
        end

        assert_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drive[i]) |-> (quiet >= $past(delay)));
    end

    assign out_a = drive[0];
    assign out_b = drive[1];

    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a && out_b));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dis_s |=> (!out_a && !out_b));
    assert_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req == 2'b11) |=> (drive == 2'b00));
endmodule

// File: tb/sim_dti_interlock.sv
module sim_dti_interlock;
    localparam int SCALE = 2, OFFSET = 3, CODE_MAX = 12;
    localparam int DMAX  = SCALE * CODE_MAX + OFFSET;

    logic       clk = 1'b0, rst_n = 1'b0, hold_off = 1'b0, in_a = 1'b0, in_b = 1'b0;
    logic [3:0] dt_code = 4'd2;
    logic       out_a, out_b;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    // cycle-level reference state
    logic m1a = 0, m1b = 0, m1d = 0, m2a = 0, m2b = 0, m2d = 0, ma = 0, mb = 0;
    int   ca = 0, cb = 0;
    int   lowa = 0, lowb = 0;
    logic pa = 0, pb = 0;

    always #10 clk = ~clk;

    dti_interlock u0 (
        .clk(clk), .rst_n(rst_n), .hold_off(hold_off), .dt_code(dt_code),
        .in_a(in_a), .in_b(in_b), .out_a(out_a), .out_b(out_b)
    );

    function automatic int dt_of(input int code);
        int c = (code > CODE_MAX) ? CODE_MAX : code;
        return SCALE * c + OFFSET;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic a, input logic b, input logic d);
        int   dl = dt_of(int'(dt_code));
        logic ba = m2b | m2d;
        logic bb = m2a | m2d;
        logic na = m2a & ~ba & (ca >= dl);
        logic nb = m2b & ~bb & (cb >= dl);
        int   nca = ba ? 0 : ((ca < DMAX) ? ca + 1 : ca);
        int   ncb = bb ? 0 : ((cb < DMAX) ? cb + 1 : cb);
        ma = na; mb = nb; ca = nca; cb = ncb;
        m2a = m1a; m2b = m1b; m2d = m1d;
        m1a = a;   m1b = b;   m1d = d;
    endtask

    task automatic cyc(input logic a, input logic b, input logic d, input string tag);
        chk({tag, " out_a"}, int'(out_a), int'(ma));
        chk({tag, " out_b"}, int'(out_b), int'(mb));
        chk("R11 exclusive", int'(out_a & out_b), 0);
        if (out_a && !pa) chk("R4 gap before out_a", int'(lowb >= dt_of(int'(dt_code))), 1);
        if (out_b && !pb) chk("R4 gap before out_b", int'(lowa >= dt_of(int'(dt_code))), 1);
        lowa = out_a ? 0 : lowa + 1;
        lowb = out_b ? 0 : lowb + 1;
        pa = out_a; pb = out_b;
        in_a = a; in_b = b; hold_off = d;
        model_step(a, b, d);
        @(negedge clk);
    endtask

    // sel: 0 first high a, 1 first high b, 2 first low a, 3 first low b
    task automatic hold(input logic a, input logic b, input logic d, input int n,
                        input string tag, input int sel, output int first);
        first = -1;
        for (int k = 0; k < n; k++) begin
            logic v = sel[0] ? out_b : out_a;
            if (first < 0 && v === (sel < 2)) first = k;
            cyc(a, b, d, tag);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int f;
        int unsigned seed = $urandom(32'd4242);
        in_a = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R1 reset out_a", int'(out_a), 0);
            chk("R1 reset out_b", int'(out_b), 0);
        end
        rst_n = 1'b1;
        hold(1, 0, 0, 30, "R1", 0, f);       chk("R1 first rise", f, dt_of(2) + 1);
        hold(0, 1, 0, 40, "R4", 1, f);       chk("R4 R6 swap", f, 3 + dt_of(2));
        hold(0, 0, 0, 20, "R3", 3, f);       chk("R3 fall b", f, 3);
        hold(1, 0, 0, 20, "R5", 0, f);       chk("R5 R2 wide gap", f, 3);
        hold(0, 0, 0, 20, "R3", 2, f);       chk("R3 fall a", f, 3);
        hold(1, 0, 0, 20, "R2", 0, f);       chk("R2 rise a", f, 3);
        hold(0, 1, 0, 5, "R9", 1, f);        chk("R9 no early b", f, -1);
        hold(0, 0, 0, 30, "R9", 1, f);       chk("R9 cancelled b", f, -1);
        hold(1, 0, 0, 20, "R2", 0, f);
        hold(1, 1, 0, 12, "R7", 2, f);       chk("R7 overlap a low", f, 3);
        hold(0, 1, 0, 30, "R8", 1, f);       chk("R8 after overlap", f, 3 + dt_of(2));
        hold(0, 1, 1, 10, "R10", 3, f);      chk("R10 hold low", f, 3);
        hold(0, 1, 0, 30, "R10", 1, f);      chk("R10 release wait", f, 3 + dt_of(2));
        hold(0, 0, 1, 6, "R10", 1, f);
        dt_code = 4'd15;
        hold(1, 0, 0, 50, "R12", 0, f);      chk("R12 code 15", f, 3 + DMAX);
        hold(0, 0, 1, 6, "R10", 0, f);
        dt_code = 4'd12;
        hold(1, 0, 0, 50, "R12", 0, f);      chk("R12 code 12", f, 3 + DMAX);
        foreach (seed[i]) if (i < 3) begin
            logic ra = 0, rb = 0, rd;
            hold(0, 0, 1, 6, "R10", 0, f);
            dt_code = (i == 0) ? 4'd0 : ((i == 1) ? 4'd5 : 4'd13);
            for (int k = 0; k < 4000; k++) begin
                if ($urandom_range(9) == 0) ra = ~ra;
                if ($urandom_range(9) == 0) rb = ~rb;
                rd = ($urandom_range(199) == 0);
                cyc(ra, rb, rd, "R2 random");
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule